// File: doc/BRIEF.md
# Temperature sensor configuration and one-shot sequencer

This block holds the configuration byte of a serial-bus temperature sensor and runs its conversion cycle. A byte-level bus front end, outside this block, presents received bits one at a time together with an end-of-transfer event that marks a stop or a repeated start. The first byte of each transfer selects a register. When it selects the configuration register, the next complete byte is stored and every later byte is dropped. The stored byte sets shutdown, the conversion resolution and the one-shot request.

The sequencer runs conversions back to back while shutdown is clear. While shutdown is set it stays idle, and a one-shot request makes it run exactly one conversion. Each conversion lasts a base count of clock cycles, doubled once for each resolution step above the lowest. The resolution is taken when a conversion starts. When a conversion ends, the sample on the ADC stand-in port is loaded into a 16-bit left-justified result register, with every bit below the selected precision cleared.

Top module: `tsense_cfg_seq`

## Requirements
- R1: While reset is held, `cfg_rd`, `temp_q` and `busy` are 0. After reset the block runs continuously at code 00, and the first `conv_done` pulse appears CONV_BASE+1 cycles after reset is released.
- R2: A transfer whose first byte is 0x01, followed by a full data byte, stores that byte, which appears on `cfg_rd` with bit 7 always read as 0. Shutdown is bit 0, bit 7 is the one-shot request, and the 2-bit resolution code sits at bits RES_LSB+1:RES_LSB.
- R3: Bytes after the first data byte of the same transfer do not change `cfg_rd`.
- R4: If `bus_end` arrives before all 8 bits of the data byte have been received, `cfg_rd` keeps its previous value.
- R5: A transfer whose first byte is not 0x01 does not change `cfg_rd`.
- R6: With shutdown clear, `conv_done` pulses every CONV_BASE<<code cycles, using the resolution code held when each conversion started.
- R7: On each `conv_done` pulse, `temp_q` equals the ADC sample taken on the finishing cycle ANDed with 16'hFFFF << (7-code). This gives 9, 10, 11 or 12 significant bits for codes 00, 01, 10 and 11. `temp_q` changes at no other time.
- R8: Setting shutdown during a conversion lets that conversion finish with one `conv_done` pulse. After that, `busy` stays low and no further pulse occurs.
- R9: Writing bit 7 = 1 and bit 0 = 1 while shutdown is already set gives exactly one conversion with a correct result. The block then returns idle, and `cfg_rd` shows bit 7 as 0.
- R10: A byte with bit 7 = 1 written while shutdown was clear starts no one-shot conversion, even if the same byte sets shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_bit_vld | input | 1 | One received bus bit is valid this cycle |
| bus_bit | input | 1 | Received bit value, most significant bit first |
| bus_end | input | 1 | Stop or repeated start; ends the transfer |
| adc_sample | input | 16 | ADC stand-in sample, left-justified two's complement |
| cfg_rd | output | 8 | Configuration readback, bit 7 always 0 |
| temp_q | output | 16 | Result register |
| busy | output | 1 | A conversion is in progress |
| conv_done | output | 1 | One-cycle pulse after each result update |

## Verification
The bench builds the block with CONV_BASE = 8, so conversions take 8, 16, 32 or 64 cycles. At that length, all four resolution codes can be swept, each with exact interval and mask checks. The short base also leaves a configuration write of about 17 cycles landing inside a single 32-cycle conversion. That is what lets the bench exercise the cases of shutdown arriving mid-conversion and of a one-shot requested from continuous mode. The ADC stand-in changes on every cycle, so a result captured on the wrong cycle or with the wrong mask shows up as a mismatch.

// File: rtl/tsense_pkg.sv
package tsense_pkg;
   localparam int CFG_W    = 8;
   localparam int SD_BIT   = 0;
   localparam int OS_BIT   = 7;
   localparam int RES_W    = 2;
   localparam int RES_NUM  = 1 << RES_W;
   typedef enum logic {SQ_IDLE, SQ_CONV} seq_st_t;
endpackage

// File: rtl/tsense_cfg_cap.sv
module tsense_cfg_cap
   import tsense_pkg::*;
#(
   parameter logic [CFG_W-1:0] CFG_PTR = 8'h01
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_vld,
   input  logic             bit_in,
   input  logic             xfer_end,
   output logic [CFG_W-1:0] cfg_q,
   output logic             os_req
);
   localparam int BC_W = $clog2(CFG_W);

   logic [CFG_W-1:0] shreg;
   logic [CFG_W-1:0] nxt;
   logic [BC_W-1:0]  bit_cnt;
   logic [1:0]       byte_idx;
   logic             ptr_hit;
   logic             last_bit;
   logic             wr_pls;

   assign nxt      = {shreg[CFG_W-2:0], bit_in};
   assign last_bit = bit_vld && !xfer_end && (bit_cnt == BC_W'(CFG_W-1));
   assign wr_pls   = last_bit && (byte_idx == 2'd1) && ptr_hit;
   assign os_req   = wr_pls && nxt[OS_BIT] && nxt[SD_BIT] && cfg_q[SD_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg    <= '0;
         bit_cnt  <= '0;
         byte_idx <= 2'd0;
         ptr_hit  <= 1'b0;
      end else if (xfer_end) begin
         bit_cnt  <= '0;
         byte_idx <= 2'd0;
         ptr_hit  <= 1'b0;
      end else if (bit_vld) begin
         shreg   <= nxt;
         bit_cnt <= bit_cnt + BC_W'(1);
         if (last_bit) begin
            if (byte_idx == 2'd0) ptr_hit <= (nxt == CFG_PTR);
            if (byte_idx != 2'd2) byte_idx <= byte_idx + 2'd1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q <= '0;
      else if (wr_pls) cfg_q <= nxt & ~(CFG_W'(1) << OS_BIT);
   end

   // R4
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_end || !bit_vld) |=> $stable(cfg_q));
endmodule

// File: rtl/tsense_conv_seq.sv
module tsense_conv_seq
   import tsense_pkg::*;
#(
   parameter int CONV_BASE = 25000,
   localparam int CNT_W = $clog2(CONV_BASE << (RES_NUM-1)) + 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sd,
   input  logic [RES_W-1:0] res,
   input  logic             os_req,
   output logic             busy,
   output logic             fin,
   output logic             done,
   output logic [RES_W-1:0] res_l
);
   seq_st_t          st;
   logic [CNT_W-1:0] cnt;
   logic             os_pend;
   logic             os_run;

   function automatic logic [CNT_W-1:0] conv_len(input logic [RES_W-1:0] r);
      return CNT_W'(CONV_BASE) << r;
   endfunction

   if (CONV_BASE < 2) begin : g_bad_base
      $error("CONV_BASE must be at least 2");
   end

   assign busy = (st == SQ_CONV);
   assign fin  = busy && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= SQ_IDLE;
         cnt     <= '0;
         done    <= 1'b0;
         os_pend <= 1'b0;
         os_run  <= 1'b0;
         res_l   <= '0;
      end else begin
         done <= 1'b0;
         case (st)
            SQ_IDLE: begin
               if (!sd || os_pend) begin
                  st     <= SQ_CONV;
                  cnt    <= conv_len(res) - CNT_W'(1);
                  res_l  <= res;
                  os_run <= sd;
               end
            end
            default: begin
               if (fin) begin
                  done <= 1'b1;
                  if (os_run) os_pend <= 1'b0;
                  if (!sd) begin
                     cnt    <= conv_len(res) - CNT_W'(1);
                     res_l  <= res;
                     os_run <= 1'b0;
                  end else begin
                     st <= SQ_IDLE;
                  end
               end else begin
                  cnt <= cnt - CNT_W'(1);
               end
            end
         endcase
         if (os_req) os_pend <= 1'b1;
      end
   end

   // R6
   done_after_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy));
   // R6
   res_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !fin) |=> $stable(res_l));
   // R9
   oneshot_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && os_run && sd && !os_pend) |=> !busy);
endmodule

// File: rtl/tsense_res_fmt.sv
module tsense_res_fmt
   import tsense_pkg::*;
#(
   parameter int OUT_W   = 16,
   parameter int MIN_RES = 9
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fin,
   input  logic [RES_W-1:0] res_l,
   input  logic [OUT_W-1:0] adc,
   output logic [OUT_W-1:0] temp
);
   logic [OUT_W-1:0] mask_tab [RES_NUM];

   if (MIN_RES + RES_NUM - 1 > OUT_W) begin : g_bad_width
      $error("result width too small for the resolution range");
   end

   for (genvar i = 0; i < RES_NUM; i++) begin : g_mask
      assign mask_tab[i] = {OUT_W{1'b1}} << (OUT_W - MIN_RES - i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   temp <= '0;
      else if (fin) temp <= adc & mask_tab[res_l];
   end

   // R7
   temp_only_on_fin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fin |=> $stable(temp));
endmodule

// File: rtl/tsense_cfg_seq.sv
module tsense_cfg_seq
   import tsense_pkg::*;
#(
   parameter int CONV_BASE = 25000,
   parameter int RES_LSB   = 5,
   parameter int OUT_W     = 16
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_bit_vld,
   input  logic             bus_bit,
   input  logic             bus_end,
   input  logic [OUT_W-1:0] adc_sample,
   output logic [CFG_W-1:0] cfg_rd,
   output logic [OUT_W-1:0] temp_q,
   output logic             busy,
   output logic             conv_done
);
   logic [CFG_W-1:0] cfg_q;
   logic             os_req;
   logic             fin;
   logic [RES_W-1:0] res_l;

   if (RES_LSB < 1 || RES_LSB + RES_W > OS_BIT) begin : g_bad_lsb
      $error("resolution field overlaps shutdown or one-shot bit");
   end

   tsense_cfg_cap u_cap (
      .clk(clk), .rst_n(rst_n), .bit_vld(bus_bit_vld), .bit_in(bus_bit),
      .xfer_end(bus_end), .cfg_q(cfg_q), .os_req(os_req)
   );

   tsense_conv_seq #(.CONV_BASE(CONV_BASE)) u_seq (
      .clk(clk), .rst_n(rst_n), .sd(cfg_q[SD_BIT]),
      .res(cfg_q[RES_LSB +: RES_W]), .os_req(os_req), .busy(busy),
      .fin(fin), .done(conv_done), .res_l(res_l)
   );

   tsense_res_fmt #(.OUT_W(OUT_W)) u_fmt (
      .clk(clk), .rst_n(rst_n), .fin(fin), .res_l(res_l),
      .adc(adc_sample), .temp(temp_q)
   );

   assign cfg_rd = cfg_q;
endmodule

// File: tb/sim_tsense_cfg_seq.sv
`timescale 1ns/1ps
module sim_tsense_cfg_seq;
   localparam int BASE = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_bit_vld = 1'b0;
   logic        bus_bit = 1'b0;
   logic        bus_end = 1'b0;
   logic [15:0] adc_sample = 16'hACE1;
   logic [15:0] adc_prev = 16'h0;
   logic [7:0]  cfg_rd;
   logic [15:0] temp_q;
   logic        busy;
   logic        conv_done;
   int          cyc = 0;
   int          n_chk = 0;
   int          n_err = 0;

   always #10 clk = ~clk;

   tsense_cfg_seq #(.CONV_BASE(BASE)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_bit_vld(bus_bit_vld), .bus_bit(bus_bit),
      .bus_end(bus_end), .adc_sample(adc_sample), .cfg_rd(cfg_rd),
      .temp_q(temp_q), .busy(busy), .conv_done(conv_done)
   );

   always @(posedge clk) begin
      cyc        <= cyc + 1;
      adc_prev   <= adc_sample;
      adc_sample <= {adc_sample[14:0],
                     adc_sample[15] ^ adc_sample[13] ^ adc_sample[12] ^ adc_sample[10]};
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] mask_of(input int r);
      return 16'hFFFF << (7 - r);
   endfunction

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         @(negedge clk);
         bus_bit_vld = 1'b1;
         bus_bit     = b[i];
      end
      @(negedge clk);
      bus_bit_vld = 1'b0;
   endtask

   task automatic end_txn();
      @(negedge clk);
      bus_end = 1'b1;
      @(negedge clk);
      bus_end = 1'b0;
   endtask

   task automatic write_cfg(input logic [7:0] ptr, input logic [7:0] d);
      send_bits(ptr, 8);
      send_bits(d, 8);
      end_txn();
   endtask

   // waits for conv_done; optionally checks the result mask against code r
   task automatic wait_done(output int t, input bit do_chk, input int r, input string tag);
      int guard = 0;
      do begin
         @(negedge clk);
         guard++;
      end while (!conv_done && guard < 1000);
      t = cyc;
      if (do_chk)
         chk(conv_done && temp_q == (adc_prev & mask_of(r)), tag, temp_q, adc_prev & mask_of(r));
   endtask

   task automatic count_done(input int n, output int cnt);
      cnt = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (conv_done) cnt++;
      end
   endtask

   initial begin
      #(20 * 150000);
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      int t0, t1, t2, k, cnt;
      // R1 reset state
      repeat (3) @(negedge clk);
      chk(cfg_rd == 8'h00, "R1 cfg reset", cfg_rd, 0);
      chk(temp_q == 16'h0, "R1 temp reset", temp_q, 0);
      chk(busy == 1'b0, "R1 busy reset", busy, 0);
      rst_n = 1'b1;
      k = 0;
      do begin
         @(negedge clk);
         k++;
      end while (!conv_done && k < 100);
      chk(k == BASE + 1, "R1 first conversion latency", k, BASE + 1);
      chk(temp_q == (adc_prev & mask_of(0)), "R7 first result code 00", temp_q, adc_prev & mask_of(0));

      // R2 store and read back, bit 7 reads 0
      write_cfg(8'h01, 8'hDE);
      chk(cfg_rd == 8'h5E, "R2 readback", cfg_rd, 8'h5E);
      // R3 extra bytes dropped
      send_bits(8'h01, 8); send_bits(8'h22, 8); send_bits(8'h7C, 8); end_txn();
      chk(cfg_rd == 8'h22, "R3 extra byte ignored", cfg_rd, 8'h22);
      // R4 partial byte dropped
      send_bits(8'h01, 8); send_bits(8'h7F, 5); end_txn();
      chk(cfg_rd == 8'h22, "R4 partial byte", cfg_rd, 8'h22);
      send_bits(8'h01, 6); end_txn();
      send_bits(8'h44, 8); end_txn();
      chk(cfg_rd == 8'h22, "R4 partial pointer", cfg_rd, 8'h22);
      // R5 other pointer
      write_cfg(8'h03, 8'h60);
      chk(cfg_rd == 8'h22, "R5 other pointer", cfg_rd, 8'h22);

      // R6 / R7 sweep all resolution codes in continuous mode
      for (int r = 0; r < 4; r++) begin
         write_cfg(8'h01, 8'(r << 5));
         wait_done(t0, 1'b0, r, "");
         wait_done(t1, 1'b1, r, "R7 result mask");
         wait_done(t2, 1'b1, r, "R7 result mask");
         chk(t2 - t1 == (BASE << r), "R6 period", t2 - t1, BASE << r);
      end

      // R8 shutdown mid-conversion
      write_cfg(8'h01, 8'h40);
      wait_done(t0, 1'b0, 2, "");
      wait_done(t0, 1'b1, 2, "R7 result code 10");
      write_cfg(8'h01, 8'h41);
      wait_done(t1, 1'b1, 2, "R8 final result");
      chk(t1 - t0 == (BASE << 2), "R8 current conversion completes", t1 - t0, BASE << 2);
      count_done(150, cnt);
      chk(cnt == 0, "R8 no further conversion", cnt, 0);
      chk(busy == 1'b0, "R8 idle after shutdown", busy, 0);

      // R9 one-shot in shutdown
      write_cfg(8'h01, 8'hC1);
      chk(cfg_rd == 8'h41, "R9 one-shot bit reads 0", cfg_rd, 8'h41);
      wait_done(t0, 1'b1, 2, "R9 one-shot result");
      count_done(150, cnt);
      chk(cnt == 0, "R9 exactly one conversion", cnt, 0);
      chk(busy == 1'b0, "R9 back to idle", busy, 0);
      write_cfg(8'h01, 8'h81);
      wait_done(t0, 1'b1, 0, "R9 one-shot code 00");
      count_done(100, cnt);
      chk(cnt == 0 && !busy, "R9 single code 00 conversion", cnt, 0);

      // R10 one-shot requested while continuous
      write_cfg(8'h01, 8'h40);
      wait_done(t0, 1'b0, 2, "");
      wait_done(t0, 1'b0, 2, "");
      write_cfg(8'h01, 8'hC1);
      wait_done(t1, 1'b1, 2, "R10 last continuous result");
      count_done(150, cnt);
      chk(cnt == 0, "R10 no one-shot from continuous", cnt, 0);
      chk(busy == 1'b0, "R10 idle", busy, 0);

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule